// File: doc/BRIEF.md
# UART FIFO Control and Transmit Trigger Interrupt

This block holds the write-only FIFO control byte of one UART channel and drives the FIFO-side control lines that follow from it. A single write can switch both FIFOs on or off, request a pointer reset of either FIFO, pick the receive and transmit trigger indices, and record a legacy block-transfer mode bit. The FIFO memories and shift registers sit outside this block. They receive one-cycle reset pulses and report their fill counts back.

The trigger levels come from four constant tables. A two-bit table select, held in a separate register elsewhere, indexes them, and that select always serves both directions at once. The block also raises the transmit-trigger interrupt from the transmit fill count. The interrupt depends on whether the FIFO was filled above its trigger since it was last empty. If it was, the interrupt asserts when the count drops below the trigger. If it was not, the interrupt asserts only when the FIFO is empty.

All pins are plain control and status. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_fifo_ctl`

## Requirements
- R1: While `rst_n` is low and after its release, `fifo_en`, `xfer_mode`, `rx_fifo_rst` and `tx_fifo_rst` are 0, and both trigger indices are 00.
- R2: A write with `wr_data[0]`=1 sets `fifo_en` and stores `wr_data[3]` on `xfer_mode`. A write with `wr_data[0]`=0 clears `fifo_en` and leaves the mode bit, both trigger indices and both reset lines unchanged or idle. The mode bit alters no other output.
- R3: A write with `wr_data[0]`=1 and `wr_data[1]`=1 drives `rx_fifo_rst` high for exactly the one cycle that follows the write. The pulse is not held.
- R4: A write with `wr_data[0]`=1 and `wr_data[2]`=1 drives `tx_fifo_rst` high for exactly the one cycle that follows the write.
- R5: The transmit trigger index takes `wr_data[5:4]` only on a write with `wr_data[0]`=1 while `enh_en`=1. Otherwise it is kept.
- R6: The receive trigger index takes `wr_data[7:6]` on any write with `wr_data[0]`=1.
- R7: `tbl_sel` applies to both directions in the same cycle. With indices 0..3, the transmit level tables are: table 0 {1,8,16,32}, table 1 {16,8,24,30}, table 2 {16,32,48,56}, table 3 {8,16,32,56}. The receive level tables are: table 0 {1,4,8,14}, table 1 {8,16,24,28}, table 2 {8,16,56,60}, table 3 {8,16,56,60}.
- R8: While the FIFO has not been filled above the trigger since it was last empty, `tx_irq` equals (`tx_count`==0).
- R9: A clock edge with `tx_count` greater than the transmit level marks the FIFO as filled. An edge with `tx_count`==0 clears that mark. While the mark is set, `tx_irq` equals (`tx_count` < transmit level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte |
| tbl_sel | input | 2 | Trigger table select shared by both directions |
| enh_en | input | 1 | Enhanced-features enable; gates transmit index writes |
| tx_count | input | 7 | Transmit FIFO fill count, 0..64 |
| fifo_en | output | 1 | Both FIFOs enabled |
| xfer_mode | output | 1 | Stored block-transfer mode bit |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO pointer reset |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO pointer reset |
| rx_trig_lvl | output | 7 | Selected receive trigger level |
| tx_trig_lvl | output | 7 | Selected transmit trigger level |
| tx_irq | output | 1 | Transmit trigger interrupt |

## Verification
Two things can land on the same edge: a control write that changes the transmit trigger index, and the fill-mark update that compares `tx_count` against the transmit level. The random phase writes control bytes while the fill count moves in a random walk across the trigger, so a write often arrives on the cycle the count crosses. A directed case forces this crossing on purpose. The bench's model updates the mark against the level in force before the write, and applies the new level only from the next cycle. The interrupt in the cycles around each crossing is checked against that model.

// File: rtl/uart_fifo_ctl_pkg.sv
package uart_fifo_ctl_pkg;
  localparam int LVL_W = 7;

  typedef struct packed {
    logic       en;
    logic       mode;
    logic [1:0] rx_idx;
    logic [1:0] tx_idx;
  } fcr_t;

  // transmit level tables, selected by {table, index}
  function automatic logic [LVL_W-1:0] tx_level(input logic [1:0] tbl, input logic [1:0] idx);
    logic [LVL_W-1:0] v;
    case ({tbl, idx})
      4'h0: v = 7'd1;   4'h1: v = 7'd8;   4'h2: v = 7'd16;  4'h3: v = 7'd32;
      4'h4: v = 7'd16;  4'h5: v = 7'd8;   4'h6: v = 7'd24;  4'h7: v = 7'd30;
      4'h8: v = 7'd16;  4'h9: v = 7'd32;  4'hA: v = 7'd48;  4'hB: v = 7'd56;
      4'hC: v = 7'd8;   4'hD: v = 7'd16;  4'hE: v = 7'd32;  default: v = 7'd56;
    endcase
    return v;
  endfunction

  // receive level tables
  function automatic logic [LVL_W-1:0] rx_level(input logic [1:0] tbl, input logic [1:0] idx);
    logic [LVL_W-1:0] v;
    case ({tbl, idx})
      4'h0: v = 7'd1;   4'h1: v = 7'd4;   4'h2: v = 7'd8;   4'h3: v = 7'd14;
      4'h4: v = 7'd8;   4'h5: v = 7'd16;  4'h6: v = 7'd24;  4'h7: v = 7'd28;
      4'h8, 4'hC: v = 7'd8;
      4'h9, 4'hD: v = 7'd16;
      4'hA, 4'hE: v = 7'd56;
      default:    v = 7'd60;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
  import uart_fifo_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       enh_en,
  output fcr_t       cfg,
  output logic       rx_rst,
  output logic       tx_rst
);
  logic armed;
  assign armed = wr_en & wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      rx_rst <= 1'b0;
      tx_rst <= 1'b0;
    end else begin
      rx_rst <= armed & wr_data[1];
      tx_rst <= armed & wr_data[2];
      if (armed) begin
        cfg.en     <= 1'b1;
        cfg.mode   <= wr_data[3];
        cfg.rx_idx <= wr_data[7:6];
        if (enh_en) cfg.tx_idx <= wr_data[5:4];
      end else if (wr_en) begin
        cfg.en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ufc_trig_lut.sv
module ufc_trig_lut
  import uart_fifo_ctl_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  logic [1:0]       tbl_sel,
  input  logic [1:0]       idx,
  output logic [LVL_W-1:0] level
);
  generate
    if (IS_TX) begin : g_tx
      assign level = tx_level(tbl_sel, idx);
    end else begin : g_rx
      assign level = rx_level(tbl_sel, idx);
    end
  endgenerate
endmodule

// File: rtl/ufc_tx_irq.sv
module ufc_tx_irq #(
  parameter int CNT_W = 7,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [LVL_W-1:0] level,
  output logic             irq
);
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;
  logic [CMP_W-1:0] cnt_x, lvl_x;
  logic             filled, is_empty;

  assign cnt_x    = CMP_W'(count);
  assign lvl_x    = CMP_W'(level);
  assign is_empty = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              filled <= 1'b0;
    else if (is_empty)       filled <= 1'b0;
    else if (cnt_x > lvl_x)  filled <= 1'b1;
  end

  assign irq = filled ? (cnt_x < lvl_x) : is_empty;
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_ctl_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       tbl_sel,
  input  logic             enh_en,
  input  logic [CNT_W-1:0] tx_count,
  output logic             fifo_en,
  output logic             xfer_mode,
  output logic             rx_fifo_rst,
  output logic             tx_fifo_rst,
  output logic [LVL_W-1:0] rx_trig_lvl,
  output logic [LVL_W-1:0] tx_trig_lvl,
  output logic             tx_irq
);
  localparam int N_DIR = 2;  // 0 = receive, 1 = transmit

  fcr_t             cfg;
  logic [1:0]       dir_idx [N_DIR];
  logic [LVL_W-1:0] dir_lvl [N_DIR];

  ufc_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .enh_en(enh_en), .cfg(cfg), .rx_rst(rx_fifo_rst), .tx_rst(tx_fifo_rst)
  );

  assign dir_idx[0] = cfg.rx_idx;
  assign dir_idx[1] = cfg.tx_idx;

  generate
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      ufc_trig_lut #(.IS_TX(d == 1)) u_lut (
        .tbl_sel(tbl_sel), .idx(dir_idx[d]), .level(dir_lvl[d])
      );
    end
  endgenerate

  ufc_tx_irq #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .count(tx_count), .level(dir_lvl[1]), .irq(tx_irq)
  );

  assign fifo_en     = cfg.en;
  assign xfer_mode   = cfg.mode;
  assign rx_trig_lvl = dir_lvl[0];
  assign tx_trig_lvl = dir_lvl[1];
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int CNT_W = 7,
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [1:0]       tbl_sel,
  input logic             enh_en,
  input logic [CNT_W-1:0] tx_count,
  input logic             fifo_en,
  input logic             rx_fifo_rst,
  input logic             tx_fifo_rst,
  input logic [LVL_W-1:0] tx_trig_lvl,
  input logic             tx_irq
);
  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(fifo_en));
  // R2
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> !fifo_en);
  // R3
  rx_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_rst |-> $past(wr_en && wr_data[0] && wr_data[1]));
  // R4
  tx_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_rst |-> $past(wr_en && wr_data[0] && wr_data[2]));
  // R5
  tx_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[0] && enh_en) |=> (!$stable(tbl_sel) || $stable(tx_trig_lvl)));
  // R8
  empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |-> tx_irq);
  // R9
  above_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(tx_trig_lvl) <= tx_count) |-> !tx_irq);
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.CNT_W(CNT_W), .LVL_W(uart_fifo_ctl_pkg::LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tbl_sel(tbl_sel),
  .enh_en(enh_en), .tx_count(tx_count), .fifo_en(fifo_en), .rx_fifo_rst(rx_fifo_rst),
  .tx_fifo_rst(tx_fifo_rst), .tx_trig_lvl(tx_trig_lvl), .tx_irq(tx_irq)
);

// File: tb/tb_uart_fifo_ctl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] tbl_sel = '0;
  logic       enh_en = 1'b0;
  logic [6:0] tx_count = '0;
  logic       fifo_en, xfer_mode, rx_fifo_rst, tx_fifo_rst, tx_irq;
  logic [6:0] rx_trig_lvl, tx_trig_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit       m_en, m_mode, m_rxp, m_txp, m_flag;
  bit [1:0] m_rxs, m_txs;

  always #2.5 clk = ~clk;  // 200 MHz

  uart_fifo_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tbl_sel(tbl_sel),
    .enh_en(enh_en), .tx_count(tx_count), .fifo_en(fifo_en), .xfer_mode(xfer_mode),
    .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst), .rx_trig_lvl(rx_trig_lvl),
    .tx_trig_lvl(tx_trig_lvl), .tx_irq(tx_irq)
  );

  function automatic int tx_tab(input bit [1:0] t, input bit [1:0] i);
    int v[16] = '{1, 8, 16, 32, 16, 8, 24, 30, 16, 32, 48, 56, 8, 16, 32, 56};
    return v[{t, i}];
  endfunction

  function automatic int rx_tab(input bit [1:0] t, input bit [1:0] i);
    int v[16] = '{1, 4, 8, 14, 8, 16, 24, 28, 8, 16, 56, 60, 8, 16, 56, 60};
    return v[{t, i}];
  endfunction

  function automatic bit exp_irq(input int cnt, input int lvl, input bit flag);
    return flag ? (cnt < lvl) : (cnt == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input bit [7:0] d, input bit [1:0] ts, input bit enh, input int cnt);
    int lvl;
    bit nf;
    @(negedge clk);
    wr_en = we; wr_data = d; tbl_sel = ts; enh_en = enh; tx_count = 7'(cnt);
    #1;
    lvl = tx_tab(ts, m_txs);
    chk(fifo_en == m_en, "R2 fifo_en", fifo_en, m_en);
    chk(xfer_mode == m_mode, "R2 xfer_mode", xfer_mode, m_mode);
    chk(rx_fifo_rst == m_rxp, "R3 rx_fifo_rst", rx_fifo_rst, m_rxp);
    chk(tx_fifo_rst == m_txp, "R4 tx_fifo_rst", tx_fifo_rst, m_txp);
    chk(int'(tx_trig_lvl) == lvl, "R5 R7 tx_trig_lvl", tx_trig_lvl, lvl);
    chk(int'(rx_trig_lvl) == rx_tab(ts, m_rxs), "R6 R7 rx_trig_lvl", rx_trig_lvl, rx_tab(ts, m_rxs));
    if (m_flag) chk(tx_irq == exp_irq(cnt, lvl, 1'b1), "R9 tx_irq", tx_irq, exp_irq(cnt, lvl, 1'b1));
    else        chk(tx_irq == exp_irq(cnt, lvl, 1'b0), "R8 tx_irq", tx_irq, exp_irq(cnt, lvl, 1'b0));
    nf = (cnt == 0) ? 1'b0 : ((cnt > lvl) ? 1'b1 : m_flag);
    @(posedge clk);
    m_flag = nf;
    m_rxp = we && d[0] && d[1];
    m_txp = we && d[0] && d[2];
    if (we && d[0]) begin
      m_en = 1'b1; m_mode = d[3]; m_rxs = d[7:6];
      if (enh) m_txs = d[5:4];
    end else if (we) begin
      m_en = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    bit [1:0] ts;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(fifo_en == 0 && xfer_mode == 0, "R1 enable/mode", {fifo_en, xfer_mode}, 0);
    chk(rx_fifo_rst == 0 && tx_fifo_rst == 0, "R1 pulses", {rx_fifo_rst, tx_fifo_rst}, 0);
    chk(tx_trig_lvl == 1 && rx_trig_lvl == 1, "R1 levels", {tx_trig_lvl, rx_trig_lvl}, {7'd1, 7'd1});
    rst_n = 1'b1;
    cyc(0, 8'h00, 0, 0, 0);
    // R2 R3 R4: write with enable bit low is inert for resets and indices
    cyc(1, 8'hFE, 0, 1, 0);
    cyc(0, 8'h00, 0, 1, 0);
    // enable, mode, rx index 3, resets; R5: enh low keeps tx index
    cyc(1, 8'hFF, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0);
    // R5: tx index takes 3 when enh high
    cyc(1, 8'h31, 0, 1, 0);
    // R7: sweep tables
    for (int t = 0; t < 4; t++) cyc(0, 8'h00, 2'(t), 0, 0);
    // R8/R9: table 0 index 1 -> level 8; ramp without passing, then past trigger
    cyc(1, 8'h11, 0, 1, 0);
    for (int c = 0; c <= 6; c++) cyc(0, 8'h00, 0, 0, c);
    for (int c = 6; c >= 0; c--) cyc(0, 8'h00, 0, 0, c);
    for (int c = 0; c <= 12; c++) cyc(0, 8'h00, 0, 0, c);
    for (int c = 12; c >= 0; c--) cyc(0, 8'h00, 0, 0, c);
    // same-edge: trigger change while count crosses old level 8 (to 32)
    for (int c = 5; c <= 9; c++) cyc(0, 8'h00, 0, 0, c);
    cyc(1, 8'h31, 0, 1, 9);
    cyc(0, 8'h00, 0, 0, 20);
    cyc(0, 8'h00, 0, 0, 0);
    // random phase
    cnt = 0; ts = 0;
    for (int i = 0; i < 4000; i++) begin
      int step;
      bit we;
      step = int'($urandom_range(0, 6)) - 3;
      cnt = cnt + step;
      if (cnt < 0) cnt = 0;
      if (cnt > 64) cnt = 64;
      if ($urandom_range(0, 15) == 0) cnt = 0;
      if ($urandom_range(0, 31) == 0) ts = 2'($urandom_range(0, 3));
      we = ($urandom_range(0, 9) == 0);
      cyc(we, 8'($urandom), ts, 1'($urandom), cnt);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule